// File: doc/BRIEF.md
# Burst Write Memory Slave

This block is the write side of an AXI4 memory slave. It takes one write burst at a time on the address channel. It stores the beats from the data channel in an internal RAM that is addressed by byte, and it finishes each burst with a single response on the response channel. Each byte lane of the RAM is written only when its strobe bit is set.

A static strap, `periph_mode`, selects how the beat addresses are formed. In memory mode the slave uses the requested transfer size. It can step through the burst incrementally, or it can wrap inside an aligned window. In peripheral mode the size and burst-type fields are ignored, and every burst moves forward one full bus word per beat.

A combinational read port exposes any RAM word so that the stored contents can be inspected. The port has no handshake.

Top module: `burst_write_ram`

## Requirements
- R1: Out of reset, `aw_ready` is 1, `w_ready` is 0 and `b_valid` is 0.
- R2: A burst accepted with `aw_len` = L takes exactly L+1 data beats. `w_ready` drops on the cycle after the (L+1)th beat is accepted, and `w_last` is high only on that beat.
- R3: On an accepted beat, byte lane n of the addressed word takes `w_data[8n+7:8n]` only when `w_strb[n]` is 1. The other lanes keep their old contents.
- R4: In memory mode, a burst type other than 2'b10 is incremental. Each beat moves 2^`aw_size` bytes, and every beat after the first is aligned to that size. `aw_size` must not exceed log2 of the bus width in bytes.
- R5: In memory mode, burst type 2'b10 wraps. The length must be 2, 4, 8 or 16 beats. The address stays inside an aligned window of (L+1)·2^`aw_size` bytes and wraps to the bottom of that window.
- R6: In peripheral mode, `aw_size` and `aw_burst` have no effect. Every burst is incremental and moves one full bus word per beat.
- R7: Only one burst is in flight at a time. `aw_ready` is low from the address handshake until the response handshake completes.
- R8: `b_valid` rises on the cycle after the beat with `w_last` is accepted, and it stays high until `b_ready` is sampled high. `b_resp` is always 2'b00.
- R9: `b_id` equals the `aw_id` of the burst being acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_mode | input | 1 | Static strap: 1 = peripheral addressing, 0 = memory addressing |
| aw_id | input | ID_W | Burst identifier |
| aw_addr | input | ADDR_W | Byte start address |
| aw_len | input | 8 | Beats minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | Burst type, 2'b10 = wrapping |
| aw_valid | input | 1 | Address valid |
| aw_ready | output | 1 | Address ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte lane enables |
| w_last | input | 1 | Final beat marker |
| w_valid | input | 1 | Data valid |
| w_ready | output | 1 | Data ready |
| b_id | output | ID_W | Response identifier |
| b_resp | output | 2 | Response code, always 2'b00 |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| rd_addr | input | ADDR_W-log2(DATA_W/8) | Word index for inspection |
| rd_data | output | DATA_W | Word contents at `rd_addr` |

## Verification
The hardest case to reach is a wrapping burst that starts part-way through its window, so that the address rolls back to the window base in the middle of the burst.

The bench reaches it by sweeping every transfer size against 2-, 4-, 8- and 16-beat lengths. Each start address lies inside the window but away from its base. Narrow incremental bursts start unaligned, which exercises the realignment after the first beat.

After every burst, the whole RAM is read back through the inspection port and compared with a byte model that the bench computes arithmetically.

// File: rtl/burst_write_ram.sv
module burst_write_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int ID_W   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  periph_mode,
  input  logic [ID_W-1:0]                       aw_id,
  input  logic [ADDR_W-1:0]                     aw_addr,
  input  logic [7:0]                            aw_len,
  input  logic [2:0]                            aw_size,
  input  logic [1:0]                            aw_burst,
  input  logic                                  aw_valid,
  output logic                                  aw_ready,
  input  logic [DATA_W-1:0]                     w_data,
  input  logic [DATA_W/8-1:0]                   w_strb,
  input  logic                                  w_last,
  input  logic                                  w_valid,
  output logic                                  w_ready,
  output logic [ID_W-1:0]                       b_id,
  output logic [1:0]                            b_resp,
  output logic                                  b_valid,
  input  logic                                  b_ready,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]    rd_addr,
  output logic [DATA_W-1:0]                     rd_data
);
  localparam int LANES  = DATA_W / 8;
  localparam int BSH    = $clog2(LANES);
  localparam int WIDX_W = ADDR_W - BSH;
  localparam int WORDS  = 1 << WIDX_W;
  localparam logic [2:0] FULL_SZ = 3'(BSH);

  typedef enum logic [1:0] {S_ADDR, S_DATA, S_RESP} state_t;
  state_t state;

  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        size_q;
  logic              wrap_q;
  logic [DATA_W-1:0] mem [WORDS];

  logic aw_hs, w_hs, last_beat;
  assign aw_ready  = (state == S_ADDR);
  assign w_ready   = (state == S_DATA);
  assign b_valid   = (state == S_RESP);
  assign b_id      = id_q;
  assign b_resp    = 2'b00;
  assign aw_hs     = aw_valid & aw_ready;
  assign w_hs      = w_valid & w_ready;
  assign last_beat = (cnt_q == len_q);

  logic [ADDR_W-1:0] step, span, incr_next, wrap_next;
  assign step      = {{(ADDR_W-1){1'b0}}, 1'b1} << size_q;
  assign span      = ADDR_W'({1'b0, len_q} + 9'd1) << size_q;
  assign incr_next = (addr_q & ~(step - 1'b1)) + step;
  assign wrap_next = (addr_q & ~(span - 1'b1)) | ((addr_q + step) & (span - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_ADDR;
      id_q   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      size_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      case (state)
        S_ADDR: if (aw_hs) begin
          state  <= S_DATA;
          id_q   <= aw_id;
          addr_q <= aw_addr;
          len_q  <= aw_len;
          cnt_q  <= '0;
          size_q <= periph_mode ? FULL_SZ : aw_size;
          wrap_q <= !periph_mode && (aw_burst == 2'b10);
        end
        S_DATA: if (w_hs) begin
          addr_q <= wrap_q ? wrap_next : incr_next;
          cnt_q  <= cnt_q + 8'd1;
          if (last_beat) state <= S_RESP;
        end
        S_RESP: if (b_ready) state <= S_ADDR;
        default: state <= S_ADDR;
      endcase
    end
  end

  logic [WIDX_W-1:0] widx;
  assign widx = addr_q[ADDR_W-1:BSH];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (w_hs && w_strb[i]) mem[widx][8*i +: 8] <= w_data[8*i +: 8];
    end
  end

  assign rd_data = mem[rd_addr];

  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) aw_ready |-> !w_ready && !b_valid); // R7
  AST_LAST_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n) w_hs |-> (w_last == last_beat)); // R2
  AST_RESP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) (w_hs && w_last) |=> b_valid); // R8
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (b_valid && !b_ready) |=> b_valid && $stable(b_id)); // R8
  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) b_valid |-> b_resp == 2'b00); // R8
  AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n) (w_ready || b_valid) |-> !aw_ready); // R7
  AST_SIZE_FITS: assert property (@(posedge clk) disable iff (!rst_n) (aw_hs && !periph_mode) |-> aw_size <= FULL_SZ); // R4
  AST_WRAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs && !periph_mode && aw_burst == 2'b10) |-> (aw_len == 8'd1 || aw_len == 8'd3 || aw_len == 8'd7 || aw_len == 8'd15)); // R5
endmodule

// File: tb/burst_write_ram_tb.sv
module burst_write_ram_tb;
  localparam int CLK_NS = 10;
  localparam int DW = 32, AW = 8, IW = 4;

  logic clk = 0, rst_n = 0, periph_mode = 0;
  logic [IW-1:0] aw_id = '0;
  logic [AW-1:0] aw_addr = '0;
  logic [7:0] aw_len = '0;
  logic [2:0] aw_size = '0;
  logic [1:0] aw_burst = '0;
  logic aw_valid = 0, aw_ready;
  logic [DW-1:0] w_data = '0;
  logic [3:0] w_strb = '0;
  logic w_last = 0, w_valid = 0, w_ready;
  logic [IW-1:0] b_id;
  logic [1:0] b_resp;
  logic b_valid, b_ready = 0;
  logic [5:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  burst_write_ram #(.DATA_W(DW), .ADDR_W(AW), .ID_W(IW)) u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] model [256];
  logic [3:0] next_id = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_mem(input string req);
    for (int w = 0; w < 64; w++) begin
      rd_addr = 6'(w);
      #1;
      chk(rd_data == {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]}, req, rd_data,
          {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]});
    end
  endtask

  task automatic burst(input int a0, input int len, input int sz, input logic [1:0] bt,
                       input logic [3:0] smask, input string req);
    int a, n, s, alg, lo, hi, wb;
    logic wrap;
    logic [3:0] lanes;
    logic [31:0] d;
    logic [3:0] id;
    id = next_id; next_id++;
    s = periph_mode ? 2 : sz;
    wrap = !periph_mode && bt == 2'b10;
    n = 1 << s;
    aw_id = id; aw_addr = AW'(a0); aw_len = 8'(len); aw_size = 3'(sz); aw_burst = bt; aw_valid = 1;
    while (!aw_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    aw_valid = 0;
    chk(aw_ready == 0 && w_ready == 1, "R7", {aw_ready, w_ready}, 2'b01);
    a = a0;
    for (int b = 0; b <= len; b++) begin
      d = 32'h5A000000 ^ (b * 32'h01030507) ^ (a0 << 8) ^ (sz << 4) ^ len;
      alg = a & ~(n - 1);
      lo = a % 4; hi = (alg % 4) + n;
      for (int i = 0; i < 4; i++) lanes[i] = (i >= lo) && (i < hi);
      w_data = d; w_strb = lanes & smask; w_last = (b == len); w_valid = 1;
      for (int i = 0; i < 4; i++) if (w_strb[i]) model[((a & ~3) + i) & 255] = d[8*i +: 8];
      while (!w_ready) @(negedge clk);
      chk(b_valid == 0, "R8", b_valid, 0);
      @(posedge clk); @(negedge clk);
      if (wrap) begin
        wb = n * (len + 1);
        a = ((a & ~(wb - 1)) | ((a + n) & (wb - 1))) & 255;
      end else a = (alg + n) & 255;
    end
    w_valid = 0; w_last = 0;
    chk(w_ready == 0, "R2", w_ready, 0);
    chk(b_valid == 1, "R8", b_valid, 1);
    chk(b_resp == 2'b00, "R8", b_resp, 0);
    chk(b_id == id, "R9", b_id, id);
    chk(aw_ready == 0, "R7", aw_ready, 0);
    @(negedge clk);
    chk(b_valid == 1, "R8", b_valid, 1);
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
    chk(b_valid == 0 && aw_ready == 1, "R7", {b_valid, aw_ready}, 2'b01);
    compare_mem(req);
  endtask

  logic done = 0;
  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(aw_ready == 1 && w_ready == 0 && b_valid == 0, "R1", {aw_ready, w_ready, b_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    // R2: 64-beat clearing burst; data then overwritten below
    burst(0, 63, 2, 2'b01, 4'hF, "R2");
    // R3: strobe patterns on full-width single beats
    for (int m = 0; m < 16; m++) burst(4 * m, 0, 2, 2'b01, 4'(m), "R3");
    // R4, R5: memory-mode sweep over size, length and type
    for (int sz = 0; sz < 3; sz++) begin
      for (int li = 0; li < 5; li++) begin
        int len, n, span, base;
        len = (li == 0) ? 0 : (1 << li) - 1;
        n = 1 << sz;
        base = 80 + 16 * sz;
        burst(base + 3 - (3 % n) + ((li * 5) % 4), len, sz, 2'b01, 4'hF, "R4");
        if (len > 0) begin
          span = n * (len + 1);
          burst(((base + 64) & ~(span - 1)) + (((len / 2) + 1) * n) % span, len, sz, 2'b10, 4'hF, "R5");
        end
      end
    end
    // R6: peripheral mode ignores size and wrap type
    periph_mode = 1;
    burst(36, 3, 0, 2'b10, 4'hF, "R6");
    burst(200, 7, 1, 2'b10, 4'hF, "R6");
    burst(12, 1, 0, 2'b00, 4'hF, "R6");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule